// File: doc/BRIEF.md
# Flash Power-State Controller

This block decides the power state of a flash interface model and gates the data bus. It has three states: active, standby and automatic sleep. It watches chip select, the active-low reset, the address bus and the busy flags from the program and erase engine. From these it drives the data output enable, a 2-bit power mode code, a read-valid flag and the latched read data.

Standby follows deselection, but only when no internal operation is running. Automatic sleep follows an address that has held still for a set number of cycles, and the read-control pins play no part in it. Standby floats the data bus. Sleep keeps driving the last latched data.

After standby, a chip-select access time must pass before read data counts as valid. A single "strong high" input stands in for the supply-band detection, and it picks between deep and shallow standby.

Top module: `flash_pwr_ctl`

## Requirements
- R1: While `rstN` is low, the block is forced asynchronously into the active state. In that state `powerMode` is 2'b00, `readValid` is 0 and `dataOut` is 0.
- R2: At a clock edge where `ceN` is high and neither busy flag is set, the block enters standby.
- R3: While `progBusy` or `eraseBusy` is high, the next state is active (`powerMode` 2'b00), whatever `ceN` and the address do. Once both flags clear with the address still unchanged, sleep is re-entered at the next edge.
- R4: In standby, `powerMode` is 2'b10 (deep) when `strongHigh` is 1 and 2'b01 (shallow) when it is 0.
- R5: In standby, `dataOe` is 0 whatever the level of `oeN`. This includes the part of the cycle after `ceN` has dropped and before the next edge.
- R6: Let E0 be the first edge that sees a new address. If the address then holds, no busy flag is set and `ceN` stays low, `powerMode` is 2'b11 (sleep) after edge E0+SLEEP_CYCLES. It is still 2'b00 after edge E0+SLEEP_CYCLES-1.
- R7: Toggling `oeN` and `weN` neither delays sleep entry nor ends sleep.
- R8: A change of address during sleep returns the block to active at the next edge. The stability count then restarts from zero.
- R9: In sleep, `dataOut` keeps the last latched value while `arrayData` changes. `dataOe` is high whenever `ceN` and `oeN` are low and `weN` is high.
- R10: Let E0 be the edge that leaves standby. `readValid` is 0 until edge E0+WAKE_CYCLES-1 and 1 after it. While `readValid` is 0, `dataOut` does not change.
- R11: In the active state with `readValid` high, an edge where `ceN` and `oeN` are low and `weN` is high loads `arrayData` into `dataOut`. With `weN` low, the edge leaves `dataOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, also the device reset pin |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| progBusy | input | 1 | Program operation running |
| eraseBusy | input | 1 | Erase operation running |
| strongHigh | input | 1 | High levels lie inside the tight supply band |
| arrayData | input | DW | Read data from the array |
| dataOut | output | DW | Latched read data |
| dataOe | output | 1 | Data bus driver enable |
| readValid | output | 1 | Wake time after standby has elapsed |
| powerMode | output | 2 | 00 active, 01 shallow standby, 10 deep standby, 11 sleep |

## Verification
The assertions check four rules on every cycle:
- standby never drives the bus;
- a busy flag always yields the active state;
- a fresh address during selection always prevents sleep at the next edge;
- `dataOut` is frozen both in sleep and before wake time has passed.

Some behaviour can only be shown by the bench's timed scenarios:
- the exact edge of sleep entry;
- the restart of the count after a move;
- the exact edge at which `readValid` rises;
- the deep and shallow split;
- the data held in sleep while `arrayData` changes.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_STBY   = 2'd1,
    ST_SLEEP  = 2'd2
  } pwrState_e;

  localparam logic [1:0] MODE_ACTIVE  = 2'b00;
  localparam logic [1:0] MODE_SHALLOW = 2'b01;
  localparam logic [1:0] MODE_DEEP    = 2'b10;
  localparam logic [1:0] MODE_SLEEP   = 2'b11;

  typedef struct packed {
    logic latchEn;
    logic driveEn;
  } dpStrobe_t;

endpackage

// File: rtl/flash_pwr_datapath.sv
module flash_pwr_datapath
  import flash_pwr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SLEEP_CYCLES = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] arrayData,
  input  dpStrobe_t     strb,
  output logic          addrMoved,
  output logic          stableDone,
  output logic [DW-1:0] dataOut,
  output logic          dataOe
);

  localparam int CW = $clog2(SLEEP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SLEEP_CYCLES);

  logic [AW-1:0] addrQ;
  logic [CW-1:0] cntQ;
  logic [CW-1:0] cntNext;
  logic [DW-1:0] dataQ;

  // Per-bit change detection, reduced to a single flag.
  logic [AW-1:0] bitDiff;
  for (genvar b = 0; b < AW; b++) begin : g_diff
    assign bitDiff[b] = addr[b] ^ addrQ[b];
  end
  assign addrMoved = |bitDiff;

  always_comb begin
    if (addrMoved)          cntNext = '0;
    else if (cntQ == LIMIT) cntNext = cntQ;
    else                    cntNext = cntQ + CW'(1);
  end

  assign stableDone = !addrMoved && (cntNext == LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else begin
      addrQ <= addr;
      cntQ  <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataQ <= '0;
    else if (strb.latchEn) dataQ <= arrayData;
  end

  assign dataOut = dataQ;
  assign dataOe  = strb.driveEn;

endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int WAKE_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       progBusy,
  input  logic       eraseBusy,
  input  logic       strongHigh,
  input  logic       addrMoved,
  input  logic       stableDone,
  output dpStrobe_t  strb,
  output logic [1:0] powerMode,
  output logic       readValid
);

  localparam int WCW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WCW-1:0] WAKE_LIMIT = WCW'(WAKE_CYCLES);

  pwrState_e stateQ, stateNext;
  logic [WCW-1:0] wakeQ, wakeNext;
  logic busy, readNow;

  assign busy    = progBusy | eraseBusy;
  assign readNow = !ceN && !oeN && weN;

  // Priority: idle deselection, then running operation, then address motion.
  always_comb begin
    if (ceN && !busy)           stateNext = ST_STBY;
    else if (busy || addrMoved) stateNext = ST_ACTIVE;
    else if (stableDone)        stateNext = ST_SLEEP;
    else                        stateNext = ST_ACTIVE;
  end

  always_comb begin
    if (stateNext == ST_STBY)     wakeNext = '0;
    else if (wakeQ == WAKE_LIMIT) wakeNext = wakeQ;
    else                          wakeNext = wakeQ + WCW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACTIVE;
      wakeQ  <= '0;
    end else begin
      stateQ <= stateNext;
      wakeQ  <= wakeNext;
    end
  end

  assign readValid = (wakeQ == WAKE_LIMIT);

  always_comb begin
    strb.driveEn = (stateQ != ST_STBY) && readNow;
    strb.latchEn = (stateQ == ST_ACTIVE) && readNow && readValid;
  end

  always_comb begin
    unique case (stateQ)
      ST_STBY:  powerMode = strongHigh ? MODE_DEEP : MODE_SHALLOW;
      ST_SLEEP: powerMode = MODE_SLEEP;
      default:  powerMode = MODE_ACTIVE;
    endcase
  end

endmodule

// File: rtl/flash_pwr_ctl.sv
module flash_pwr_ctl
  import flash_pwr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SLEEP_CYCLES = 12,
  parameter int WAKE_CYCLES = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          weN,
  input  logic [AW-1:0] addr,
  input  logic          progBusy,
  input  logic          eraseBusy,
  input  logic          strongHigh,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic          readValid,
  output logic [1:0]    powerMode
);

  dpStrobe_t strb;
  logic addrMoved, stableDone;

  flash_pwr_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .progBusy(progBusy), .eraseBusy(eraseBusy), .strongHigh(strongHigh),
    .addrMoved(addrMoved), .stableDone(stableDone),
    .strb(strb), .powerMode(powerMode), .readValid(readValid)
  );

  flash_pwr_datapath #(.AW(AW), .DW(DW), .SLEEP_CYCLES(SLEEP_CYCLES)) i_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .arrayData(arrayData), .strb(strb),
    .addrMoved(addrMoved), .stableDone(stableDone),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/flash_pwr_chk.sv
module flash_pwr_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          ceN,
  input logic          progBusy,
  input logic          eraseBusy,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dataOut,
  input logic          dataOe,
  input logic          readValid,
  input logic [1:0]    powerMode
);

  logic [AW-1:0] prevAddr;
  logic havePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
      havePrev <= 1'b0;
    end else begin
      prevAddr <= addr;
      havePrev <= 1'b1;
    end
  end

  // R5
  stby_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b01 || powerMode == 2'b10) |-> !dataOe);

  // R3
  busy_keeps_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy || eraseBusy) |=> (powerMode == 2'b00));

  // R8
  move_blocks_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (havePrev && !ceN && addr != prevAddr) |=> (powerMode != 2'b11));

  // R9
  sleep_holds_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b11) |=> $stable(dataOut));

  // R10
  wake_freezes_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readValid |=> $stable(dataOut));

endmodule

bind flash_pwr_ctl flash_pwr_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .progBusy(progBusy), .eraseBusy(eraseBusy),
  .addr(addr), .dataOut(dataOut), .dataOe(dataOe), .readValid(readValid),
  .powerMode(powerMode)
);

// File: tb/test_flash_pwr_ctl.sv
`timescale 1ns/1ps
module test_flash_pwr_ctl;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int S  = 12;
  localparam int W  = 5;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, progBusy, eraseBusy, strongHigh;
  logic [AW-1:0] addr;
  logic [DW-1:0] arrayData, dataOut;
  logic dataOe, readValid;
  logic [1:0] powerMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_pwr_ctl #(.AW(AW), .DW(DW), .SLEEP_CYCLES(S), .WAKE_CYCLES(W)) i_flash_pwr_ctl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .progBusy(progBusy), .eraseBusy(eraseBusy), .strongHigh(strongHigh),
    .arrayData(arrayData), .dataOut(dataOut), .dataOe(dataOe),
    .readValid(readValid), .powerMode(powerMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {ceN,oeN,weN,prog,erase,strong, addr[7:0], expMode[1:0], expOe}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {6'b111000, 8'h01, 2'b01, 1'b0},
    {6'b111001, 8'h02, 2'b10, 1'b0},
    {6'b101001, 8'h03, 2'b10, 1'b0},
    {6'b111100, 8'h04, 2'b00, 1'b0},
    {6'b111010, 8'h05, 2'b00, 1'b0},
    {6'b111000, 8'h06, 2'b01, 1'b0},
    {6'b001000, 8'h07, 2'b00, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b1; weN = 1'b1; addr = '0;
    progBusy = 1'b0; eraseBusy = 1'b0; strongHigh = 1'b0; arrayData = '0;
    repeat (2) @(negedge clk);
    chk("R1 mode in reset", 32'(powerMode), 32'd0);
    chk("R1 readValid in reset", 32'(readValid), 32'd0);
    chk("R1 dataOut in reset", 32'(dataOut), 32'd0);
    rstN = 1'b1;

    // Table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      {ceN, oeN, weN, progBusy, eraseBusy, strongHigh} = VEC[v][16:11];
      addr = VEC[v][10:3];
      step();
      chk($sformatf("R2/R3/R4 vector %0d mode", v), 32'(powerMode), 32'(VEC[v][2:1]));
      chk($sformatf("R5 vector %0d dataOe", v), 32'(dataOe), 32'(VEC[v][0]));
    end

    // R5: standby then select before the edge
    ceN = 1'b1; oeN = 1'b1; addr = 8'h10; strongHigh = 1'b0;
    step();
    chk("R2 standby again", 32'(powerMode), 32'd1);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = 8'h11; arrayData = 16'h1111;
    #1;
    chk("R5 no drive before exit edge", 32'(dataOe), 32'd0);
    step();
    chk("R5 active after exit", 32'(powerMode), 32'd0);
    chk("R5 drive after exit", 32'(dataOe), 32'd1);
    chk("R10 readValid low after exit", 32'(readValid), 32'd0);
    chk("R10 dataOut frozen", 32'(dataOut), 32'd0);

    // R10 wake window
    for (int k = 1; k < W; k++) begin
      addr = 8'(8'h20 + k); arrayData = 16'(k + 16'h0100);
      step();
      chk($sformatf("R10 readValid edge %0d", k), 32'(readValid), 32'(k == W - 1));
      chk($sformatf("R10 dataOut edge %0d", k), 32'(dataOut), 32'd0);
    end

    // R11 latch and write cycle
    arrayData = 16'hA5C3; addr = 8'h30;
    step();
    chk("R11 read latch", 32'(dataOut), 32'hA5C3);
    weN = 1'b0; arrayData = 16'h1234; addr = 8'h31;
    step();
    chk("R11 no latch on write", 32'(dataOut), 32'hA5C3);

    // R6 R7 sleep entry with control toggling
    weN = 1'b1; oeN = 1'b0; addr = 8'h40; arrayData = 16'h5A5A;
    step();
    for (int k = 1; k <= S; k++) begin
      oeN = k[0]; weN = ~k[1];
      step();
      if (k == S - 1) chk("R6 not yet asleep", 32'(powerMode), 32'd0);
      if (k == S)     chk("R7 asleep despite toggling", 32'(powerMode), 32'd3);
    end

    // R9 hold in sleep
    oeN = 1'b0; weN = 1'b1; arrayData = 16'hFFFF;
    repeat (3) step();
    chk("R9 still asleep", 32'(powerMode), 32'd3);
    chk("R9 data held", 32'(dataOut), 32'h5A5A);
    chk("R9 drive in sleep", 32'(dataOe), 32'd1);

    // R8 exit and restart
    addr = 8'h41;
    #1;
    chk("R8 exit waits for edge", 32'(powerMode), 32'd3);
    step();
    chk("R8 active after move", 32'(powerMode), 32'd0);
    for (int k = 1; k <= S; k++) begin
      step();
      if (k == S - 1) chk("R8 count restarted", 32'(powerMode), 32'd0);
      if (k == S)     chk("R8 asleep after restart", 32'(powerMode), 32'd3);
    end

    // R3 busy overrides sleep
    progBusy = 1'b1;
    step();
    chk("R3 busy wakes", 32'(powerMode), 32'd0);
    repeat (S + 2) step();
    chk("R3 busy stays active", 32'(powerMode), 32'd0);
    progBusy = 1'b0;
    step();
    chk("R3 sleep resumes", 32'(powerMode), 32'd3);

    // R1 asynchronous reset
    rstN = 1'b0;
    #1;
    chk("R1 async mode", 32'(powerMode), 32'd0);
    chk("R1 async readValid", 32'(readValid), 32'd0);
    chk("R1 async dataOut", 32'(dataOut), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule